// File: doc/BRIEF.md
# Subclock Sleep Mode Controller

This block decides when a small microcontroller running from its slow subclock goes into a low-speed sleep state, and when it leaves that state. A sleep instruction shows up as a one-cycle strobe. The controller enters sleep only when three mode bits hold one exact combination. Any other combination counts as a request for another power mode, and the controller reports it on a separate strobe. While the controller sleeps, it gates the clock enables of most peripheral groups. A few groups keep their clocks: by default the analog converter, the pulse-width modulator and the watchdog.

Interrupt requests pass through a two-stage synchronizer on the subclock. A synchronized request ends sleep only if the global mask bit is clear and that source's enable bit is set. The controller then returns to the running state and gives a one-cycle strobe that starts exception handling. A low level on the reset pin ends sleep at once and holds the controller in a reset state until the pin goes high. Neither entry nor exit ever produces that reset state by itself, so the processor registers, RAM and port latches keep their contents. All pins are plain control and status signals, and the block carries no data stream.

Top module: `subsleep_ctrl`

## Requirements
- R1: From the running state, a `sleep_stb` pulse sampled with `stby_sel`=0, `lowspd_on`=1 and `tmode_bit`=1 makes `in_sleep` high after that rising edge.
- R2: While `in_sleep` is high, `clk_en` equals `KEEP_MASK` (default 8'h07, bits 0..2 = converter, PWM, watchdog). Otherwise `clk_en` is all ones (8'hFF).
- R3: `in_reset` is high only while `rst_pin_n` is low and for the first rising edge after it returns high. Entering or leaving sleep never raises `in_reset`.
- R4: Any bit of the `NSRC`-wide request vector (default 21 sources, bit 0 through bit 20) can end sleep.
- R5: A request does not end sleep while `imask`=1 or while its bit in `irq_en` is 0. `in_sleep` then stays high.
- R6: A request is seen after two synchronizer stages. A request set up before rising edge k clears `in_sleep` and raises `wake_stb` at edge k+2.
- R7: `rst_pin_n` low clears `in_sleep` and sets `in_reset` at once, without a clock and whatever the mask bits are. The first rising edge with the pin high returns the controller to the running state.
- R8: An interrupt exit raises `wake_stb` for exactly one cycle, and the controller is then running again.
- R9: A `sleep_stb` pulse in the running state with any other bit combination leaves `in_sleep` low and raises `other_mode_stb` for one cycle.
- R10: If an enabled, unmasked request is already synchronized when sleep is entered, the controller leaves sleep at the very next rising edge and raises `wake_stb`.
- R11: Requests in the running state, and `sleep_stb` pulses while asleep, give no `wake_stb` and do not change `in_sleep`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Subclock |
| rst_pin_n | input | 1 | Active-low reset pin, asynchronous |
| sleep_stb | input | 1 | One-cycle sleep instruction strobe |
| stby_sel | input | 1 | Standby select mode bit |
| lowspd_on | input | 1 | Low-speed-on mode bit |
| tmode_bit | input | 1 | Timer mode bit |
| imask | input | 1 | Global interrupt mask (1 = masked) |
| irq_req | input | NSRC | Wake source requests, asynchronous |
| irq_en | input | NSRC | Per-source enable bits |
| in_sleep | output | 1 | Sleep state flag |
| in_reset | output | 1 | Reset hold state flag |
| clk_en | output | NGRP | Peripheral group clock enables |
| wake_stb | output | 1 | One-cycle exception-start strobe |
| other_mode_stb | output | 1 | Sleep strobe with a non-matching bit combination |

## Verification
A wrong state value shows up on `in_sleep` and `clk_en` on the edge after the fault. This includes a sleep entered on a bad bit combination or a wake that ignores the mask. The bench therefore checks both outputs on every scenario one cycle after each stimulus. A synchronizer that is one stage short or one stage long moves `wake_stb` one edge off the expected edge k+2, so the bench samples that exact cycle and the cycles on either side of it. If the reset path leaked into normal exits, `in_reset` would be raised during a wake, and the bench checks for that.

// File: rtl/subsleep_pkg.sv
`timescale 1ns/1ps
package subsleep_pkg;
  typedef enum logic [1:0] {
    ST_HOLD   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_SLEEP  = 2'd2
  } pm_state_t;
endpackage

// File: rtl/irq_sync.sv
`timescale 1ns/1ps
module irq_sync #(
  parameter int W = 21
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage1[i] <= 1'b0;
        stage2[i] <= 1'b0;
      end else begin
        stage1[i] <= d[i];
        stage2[i] <= stage1[i];
      end
    end
  end

  assign q = stage2;

  // The output may only rise one edge after the first stage was already high
  AST_TWO_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (stage2 & ~$past(stage2)) == ((stage2 & ~$past(stage2)) & $past(stage1))); // R6
endmodule

// File: rtl/wake_detect.sv
`timescale 1ns/1ps
module wake_detect #(
  parameter int W = 21
) (
  input  logic [W-1:0] req_sync,
  input  logic [W-1:0] req_en,
  input  logic         imask,
  output logic         hit
);
  logic [W-1:0] qualified;
  assign qualified = req_sync & req_en;
  assign hit = !imask && (|qualified);
endmodule

// File: rtl/clk_gate_ctrl.sv
`timescale 1ns/1ps
module clk_gate_ctrl #(
  parameter int             NGRP      = 8,
  parameter logic [NGRP-1:0] KEEP_MASK = 8'h07
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            asleep,
  output logic [NGRP-1:0] en
);
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    if (KEEP_MASK[g]) begin : g_keep
      assign en[g] = 1'b1;
    end else begin : g_gate
      assign en[g] = !asleep;
    end
  end

  AST_KEEP_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> ((en & KEEP_MASK) == KEEP_MASK)); // R2
  AST_OTHERS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> ((en & ~KEEP_MASK) == '0)); // R2
endmodule

// File: rtl/subsleep_ctrl.sv
`timescale 1ns/1ps
module subsleep_ctrl
  import subsleep_pkg::*;
#(
  parameter int              NSRC      = 21,
  parameter int              NGRP      = 8,
  parameter logic [NGRP-1:0] KEEP_MASK = 8'h07
) (
  input  logic            clk,
  input  logic            rst_pin_n,
  input  logic            sleep_stb,
  input  logic            stby_sel,
  input  logic            lowspd_on,
  input  logic            tmode_bit,
  input  logic            imask,
  input  logic [NSRC-1:0] irq_req,
  input  logic [NSRC-1:0] irq_en,
  output logic            in_sleep,
  output logic            in_reset,
  output logic [NGRP-1:0] clk_en,
  output logic            wake_stb,
  output logic            other_mode_stb
);
  pm_state_t       state;
  logic [NSRC-1:0] req_sync;
  logic            wake_hit;
  logic            enter_ok;
  logic            wake_q;
  logic            other_q;

  irq_sync #(.W(NSRC)) u_sync (
    .clk   (clk),
    .rst_n (rst_pin_n),
    .d     (irq_req),
    .q     (req_sync)
  );

  wake_detect #(.W(NSRC)) u_wake (
    .req_sync (req_sync),
    .req_en   (irq_en),
    .imask    (imask),
    .hit      (wake_hit)
  );

  assign enter_ok = !stby_sel && lowspd_on && tmode_bit;

  always_ff @(posedge clk or negedge rst_pin_n) begin
    if (!rst_pin_n) begin
      state   <= ST_HOLD;
      wake_q  <= 1'b0;
      other_q <= 1'b0;
    end else begin
      wake_q  <= 1'b0;
      other_q <= 1'b0;
      case (state)
        ST_HOLD:   state <= ST_ACTIVE;
        ST_ACTIVE: begin
          if (sleep_stb) begin
            if (enter_ok) state <= ST_SLEEP;
            else          other_q <= 1'b1;
          end
        end
        ST_SLEEP: begin
          if (wake_hit) begin
            state  <= ST_ACTIVE;
            wake_q <= 1'b1;
          end
        end
        default:   state <= ST_HOLD;
      endcase
    end
  end

  assign in_sleep       = (state == ST_SLEEP);
  assign in_reset       = (state == ST_HOLD);
  assign wake_stb       = wake_q;
  assign other_mode_stb = other_q;

  clk_gate_ctrl #(.NGRP(NGRP), .KEEP_MASK(KEEP_MASK)) u_gate (
    .clk    (clk),
    .rst_n  (rst_pin_n),
    .asleep (in_sleep),
    .en     (clk_en)
  );

  AST_ENTRY_COMBO: assert property (@(posedge clk) disable iff (!rst_pin_n)
    $rose(in_sleep) |-> $past(sleep_stb && !stby_sel && lowspd_on && tmode_bit)); // R1
  AST_HOLD_BRIEF: assert property (@(posedge clk) disable iff (!rst_pin_n)
    in_reset |=> !in_reset); // R3
  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_pin_n)
    $fell(in_sleep) |-> !$past(imask)); // R5
  AST_EXIT_STROBE: assert property (@(posedge clk) disable iff (!rst_pin_n)
    $fell(in_sleep) |-> wake_stb); // R8
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_pin_n)
    wake_stb |=> !wake_stb); // R8
  AST_OTHER_AWAKE: assert property (@(posedge clk) disable iff (!rst_pin_n)
    other_mode_stb |-> !in_sleep); // R9
  AST_ACTIVE_NO_WAKE: assert property (@(posedge clk) disable iff (!rst_pin_n)
    wake_stb |-> $past(in_sleep)); // R11
endmodule

// File: tb/subsleep_ctrl_test.sv
`timescale 1ns/1ps
module subsleep_ctrl_test;
  localparam int NSRC = 21;
  localparam int NGRP = 8;

  logic            clk = 1'b0;
  logic            rst_pin_n;
  logic            sleep_stb, stby_sel, lowspd_on, tmode_bit, imask;
  logic [NSRC-1:0] irq_req, irq_en;
  logic            in_sleep, in_reset, wake_stb, other_mode_stb;
  logic [NGRP-1:0] clk_en;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  subsleep_ctrl uut (
    .clk(clk), .rst_pin_n(rst_pin_n), .sleep_stb(sleep_stb), .stby_sel(stby_sel),
    .lowspd_on(lowspd_on), .tmode_bit(tmode_bit), .imask(imask), .irq_req(irq_req),
    .irq_en(irq_en), .in_sleep(in_sleep), .in_reset(in_reset), .clk_en(clk_en),
    .wake_stb(wake_stb), .other_mode_stb(other_mode_stb)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Enter sleep with the matching combination; checks one edge later
  task automatic go_sleep(input string tag);
    stby_sel = 1'b0; lowspd_on = 1'b1; tmode_bit = 1'b1; sleep_stb = 1'b1;
    step(1);
    sleep_stb = 1'b0;
    check({tag, " in_sleep after entry"}, in_sleep, 1);
  endtask

  task automatic t_reset();
    rst_pin_n = 1'b0;
    step(2);
    check("R3 in_reset while pin low", in_reset, 1);
    check("R2 clk_en at reset", clk_en, 8'hFF);
    rst_pin_n = 1'b1;
    step(1);
    check("R3 in_reset cleared after release", in_reset, 0);
    check("R7 running after release", in_sleep, 0);
  endtask

  task automatic t_entry_wake();
    irq_en = '1; imask = 1'b0;
    go_sleep("R1");
    check("R2 clk_en while asleep", clk_en, 8'h07);
    irq_req[0] = 1'b1;       // sampled by next edge k
    step(2);                 // edges k, k+1
    check("R6 still asleep at k+1", in_sleep, 1);
    check("R6 no strobe at k+1", wake_stb, 0);
    step(1);                 // edge k+2
    check("R6 awake at k+2", in_sleep, 0);
    check("R8 wake strobe", wake_stb, 1);
    check("R3 no reset on wake", in_reset, 0);
    check("R2 clk_en after wake", clk_en, 8'hFF);
    irq_req = '0;
    step(1);
    check("R8 strobe single cycle", wake_stb, 0);
    step(2);
  endtask

  task automatic t_bad_combos();
    for (int c = 0; c < 8; c++) begin
      if (c == 3) continue;  // {stby,lowspd,tmode} = 011 is the match
      stby_sel = c[2]; lowspd_on = c[1]; tmode_bit = c[0]; sleep_stb = 1'b1;
      step(1);
      sleep_stb = 1'b0;
      check("R9 no sleep on other combo", in_sleep, 0);
      check("R9 other_mode_stb", other_mode_stb, 1);
      step(1);
      check("R9 other_mode_stb one cycle", other_mode_stb, 0);
    end
  endtask

  task automatic t_masked();
    irq_en = '1; imask = 1'b1;
    go_sleep("R1 masked");
    irq_req[5] = 1'b1;
    step(6);
    check("R5 stays asleep when masked", in_sleep, 1);
    check("R5 no strobe when masked", wake_stb, 0);
    irq_req = '0; imask = 1'b0;
    irq_en = '0;
    irq_req[7] = 1'b1;
    step(6);
    check("R5 stays asleep when disabled", in_sleep, 1);
    // sleep strobe while asleep is ignored
    sleep_stb = 1'b1; stby_sel = 1'b1;
    step(1);
    sleep_stb = 1'b0;
    check("R11 strobe while asleep ignored", in_sleep, 1);
    check("R11 no other strobe while asleep", other_mode_stb, 0);
    irq_req = '0;
  endtask

  task automatic t_reset_exit();
    imask = 1'b1;
    @(posedge clk);
    #2 rst_pin_n = 1'b0;
    #1;
    check("R7 async exit in_sleep", in_sleep, 0);
    check("R7 async in_reset", in_reset, 1);
    step(3);
    check("R3 hold while pin low", in_reset, 1);
    rst_pin_n = 1'b1;
    step(1);
    check("R7 running after pin high", in_reset, 0);
    check("R7 not asleep after pin high", in_sleep, 0);
    imask = 1'b0;
  endtask

  task automatic t_last_source();
    irq_en = '0; irq_en[NSRC-1] = 1'b1;
    go_sleep("R1 last");
    irq_req[NSRC-1] = 1'b1;
    step(3);
    check("R4 highest source wakes", in_sleep, 0);
    check("R4 strobe from highest source", wake_stb, 1);
    irq_req = '0;
    step(3);
  endtask

  task automatic t_pending();
    irq_en = '1;
    irq_req[12] = 1'b1;
    step(3);
    check("R11 active request no strobe", wake_stb, 0);
    check("R11 active request keeps running", in_sleep, 0);
    go_sleep("R10");
    step(1);
    check("R10 immediate exit", in_sleep, 0);
    check("R10 immediate strobe", wake_stb, 1);
    irq_req = '0;
    step(3);
  endtask

  initial begin
    rst_pin_n = 1'b0; sleep_stb = 1'b0; stby_sel = 1'b0; lowspd_on = 1'b0;
    tmode_bit = 1'b0; imask = 1'b0; irq_req = '0; irq_en = '0;
    step(1);
    check("R3 in_reset at start", in_reset, 1);
    check("R7 not asleep at start", in_sleep, 0);
    t_reset();
    t_entry_wake();
    t_bad_combos();
    t_masked();
    t_reset_exit();
    t_last_source();
    t_pending();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule